// File: doc/BRIEF.md
# Sleep-Level Clock Enable Controller

This block decides which clocks and clock sources run in a small processor system that has one running state and five sleep levels. Software selects a level by writing four mode bits, a processor-off bit, an oscillator-off bit and two clock-generator-off bits, through a write strobe. The controller decodes those bits into enables for the processor clock, the peripheral clock, the slow auxiliary clock, the DC generator of the internal tunable oscillator and the crystal oscillator. The analog sources and the processor stay outside the block. The block only produces the enable levels they follow.

While the system sleeps, an interrupt request wakes it. The controller keeps a copy of the sleep bits and switches to the running state so that the handler can execute. When the handler's return strobe arrives, the copy is loaded back and the system goes back to the sleep level it left. Some sleep levels switch off the oscillator's DC generator. Waking from one of those levels holds the processor clock off for a programmable number of settle cycles. The processor clock is released only after the oscillator has had that time to stabilise.

Top module: `lpm_clock_ctrl`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) selects the running state: mode_o is 0, all five enables are 1, no sleep bits are saved, and no settle count is pending.
- R2: Mode bit positions are sr_bits[0] processor-off, sr_bits[1] oscillator-off, sr_bits[2] generator-off-low and sr_bits[3] generator-off-high. When bit 0 is clear, the mode is running (mode_o 0) whatever the other bits are. When bits 0 and 1 are both set, the mode is sleep level 4 (mode_o 5). In every other case the mode is sleep level 1+{sr_bits[3],sr_bits[2]}, giving mode_o 1 to 4 for levels 0 to 3.
- R3: Sleep level 0 turns off only the processor clock. The peripheral clock, auxiliary clock, DC generator and crystal remain enabled.
- R4: Sleep level 1 uses the same enables as level 0, with one difference: the DC generator enable follows dco_src_active, so it is off when the tunable oscillator is not the running-state clock source.
- R5: Sleep level 2 turns off the processor and peripheral clocks. The auxiliary clock, DC generator and crystal stay enabled.
- R6: Sleep level 3 turns off the processor clock, the peripheral clock and the DC generator. The auxiliary clock and crystal stay enabled.
- R7: Sleep level 4 turns off all five enables.
- R8: While the system is running and no settle count is pending, an sr_wr pulse loads sr_bits at that edge. While the system sleeps, sr_wr and reti have no effect.
- R9: An irq that is high at an edge while the system sleeps saves the current mode bits and switches to the running state at that edge. An irq that arrives while the system is running has no effect.
- R10: A reti pulse while the system is running reloads the saved bits and clears the saved copy. If reti arrives with nothing saved, the system stays in the running state. reti takes priority over sr_wr in the same cycle.
- R11: A wake from a level whose DC generator was off holds mclk_en low for settle_len cycles after the wake edge. sr_wr and reti are ignored during that window. A wake from a level whose generator was on releases mclk_en at the wake edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sr_wr | input | 1 | Write strobe for the mode bits |
| sr_bits | input | 4 | Mode bits to write |
| irq | input | 1 | Enabled interrupt request |
| reti | input | 1 | Interrupt-return strobe |
| dco_src_active | input | 1 | Tunable oscillator drives the running-state clock |
| settle_len | input | CNT_W | Settle cycles before the processor clock is released after a wake |
| mclk_en | output | 1 | Processor clock enable |
| smclk_en | output | 1 | Peripheral clock enable |
| aclk_en | output | 1 | Auxiliary clock enable |
| dcgen_en | output | 1 | Oscillator DC generator enable |
| xtal_en | output | 1 | Crystal oscillator enable |
| mode_o | output | 3 | Current mode: 0 running, 1 to 5 sleep levels 0 to 4 |

## Verification
Each write, wake or return is captured at the rising edge where its strobe is high. mode_o and the enables are decoded from registered state, so they show the new value right after that edge. The exception is dcgen_en in sleep level 1, which also follows dco_src_active immediately. After a wake that starts a settle window, mclk_en rises exactly settle_len edges after the wake edge. The bench applies inputs after a falling edge and advances a reference model at the rising edge. It compares every output at the next falling edge, so each result is checked in the cycle it is due, including every cycle of a settle window.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    localparam int BIT_CPU_OFF = 0;
    localparam int BIT_OSC_OFF = 1;
    localparam int BIT_GEN_LO  = 2;
    localparam int BIT_GEN_HI  = 3;
    localparam int MODE_BITS_W = 4;

    typedef enum logic [2:0] {
        MODE_RUN    = 3'd0,
        MODE_SLEEP0 = 3'd1,
        MODE_SLEEP1 = 3'd2,
        MODE_SLEEP2 = 3'd3,
        MODE_SLEEP3 = 3'd4,
        MODE_SLEEP4 = 3'd5
    } mode_e;

    typedef struct packed {
        logic mclk;
        logic smclk;
        logic aclk;
        logic dcgen;
        logic xtal;
    } clk_en_t;

    typedef struct packed {
        logic [MODE_BITS_W-1:0] bits;
        logic [MODE_BITS_W-1:0] saved;
    } ctx_t;

endpackage

// File: rtl/lpm_mode_decode.sv
module lpm_mode_decode
    import lpm_pkg::*;
(
    input  logic [MODE_BITS_W-1:0] bits,
    input  logic                   dco_src_active,
    output mode_e                  mode,
    output clk_en_t                en
);

    always_comb begin
        if (!bits[BIT_CPU_OFF]) begin
            mode = MODE_RUN;
        end else if (bits[BIT_OSC_OFF]) begin
            mode = MODE_SLEEP4;
        end else begin
            unique case ({bits[BIT_GEN_HI], bits[BIT_GEN_LO]})
                2'b00:   mode = MODE_SLEEP0;
                2'b01:   mode = MODE_SLEEP1;
                2'b10:   mode = MODE_SLEEP2;
                default: mode = MODE_SLEEP3;
            endcase
        end
    end

    always_comb begin
        en = '{mclk: 1'b1, smclk: 1'b1, aclk: 1'b1, dcgen: 1'b1, xtal: 1'b1};
        unique case (mode)
            MODE_RUN: ;
            MODE_SLEEP0: begin
                en.mclk = 1'b0;
            end
            MODE_SLEEP1: begin
                en.mclk  = 1'b0;
                en.dcgen = dco_src_active;
            end
            MODE_SLEEP2: begin
                en.mclk  = 1'b0;
                en.smclk = 1'b0;
            end
            MODE_SLEEP3: begin
                en.mclk  = 1'b0;
                en.smclk = 1'b0;
                en.dcgen = 1'b0;
            end
            default: begin
                en = '0;
            end
        endcase
    end

endmodule

// File: rtl/lpm_settle_timer.sv
module lpm_settle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] len,
    output logic             busy
);

    logic [CNT_W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (start) begin
            count_d = len;
        end else if (count_q != '0) begin
            count_d = count_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign busy = (count_q != '0);

endmodule

// File: rtl/lpm_clock_ctrl.sv
module lpm_clock_ctrl
    import lpm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sr_wr,
    input  logic [3:0]       sr_bits,
    input  logic             irq,
    input  logic             reti,
    input  logic             dco_src_active,
    input  logic [CNT_W-1:0] settle_len,
    output logic             mclk_en,
    output logic             smclk_en,
    output logic             aclk_en,
    output logic             dcgen_en,
    output logic             xtal_en,
    output logic [2:0]       mode_o
);

    ctx_t    ctx_d, ctx_q;
    mode_e   cur_mode;
    clk_en_t raw_en;
    logic    asleep;
    logic    settling;
    logic    settle_start;

    lpm_mode_decode u_decode (
        .bits           (ctx_q.bits),
        .dco_src_active (dco_src_active),
        .mode           (cur_mode),
        .en             (raw_en)
    );

    lpm_settle_timer #(.CNT_W(CNT_W)) u_settle (
        .clk   (clk),
        .rst   (rst),
        .start (settle_start),
        .len   (settle_len),
        .busy  (settling)
    );

    assign asleep = (cur_mode != MODE_RUN);

    // Wake, return and write sequencing
    always_comb begin
        ctx_d        = ctx_q;
        settle_start = 1'b0;
        if (asleep) begin
            if (irq) begin
                ctx_d.saved  = ctx_q.bits;
                ctx_d.bits   = '0;
                settle_start = !raw_en.dcgen;
            end
        end else if (!settling) begin
            if (reti) begin
                ctx_d.bits  = ctx_q.saved;
                ctx_d.saved = '0;
            end else if (sr_wr) begin
                ctx_d.bits = sr_bits;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q <= '0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign mclk_en  = raw_en.mclk && !settling;
    assign smclk_en = raw_en.smclk;
    assign aclk_en  = raw_en.aclk;
    assign dcgen_en = raw_en.dcgen;
    assign xtal_en  = raw_en.xtal;
    assign mode_o   = cur_mode;

endmodule

// File: rtl/lpm_clock_ctrl_chk.sv
module lpm_clock_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       irq,
    input logic       mclk_en,
    input logic       smclk_en,
    input logic       aclk_en,
    input logic       dcgen_en,
    input logic       xtal_en,
    input logic [2:0] mode_o
);

    p_sleep_mclk_off_r3: assert property (@(posedge clk) disable iff (rst)
        (mode_o != 3'd0) |-> !mclk_en);

    p_deep_all_off_r7: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 3'd5) |-> !(mclk_en || smclk_en || aclk_en || dcgen_en || xtal_en));

    p_run_sources_on_r1: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 3'd0) |-> (smclk_en && aclk_en && dcgen_en && xtal_en));

    p_wake_to_run_r9: assert property (@(posedge clk) disable iff (rst)
        (mode_o != 3'd0 && irq) |=> (mode_o == 3'd0));

    p_sleep_holds_r8: assert property (@(posedge clk) disable iff (rst)
        (mode_o != 3'd0 && !irq) |=> $stable(mode_o));

    p_mode_legal_r2: assert property (@(posedge clk) disable iff (rst)
        mode_o <= 3'd5);

endmodule

bind lpm_clock_ctrl lpm_clock_ctrl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .irq      (irq),
    .mclk_en  (mclk_en),
    .smclk_en (smclk_en),
    .aclk_en  (aclk_en),
    .dcgen_en (dcgen_en),
    .xtal_en  (xtal_en),
    .mode_o   (mode_o)
);

// File: tb/tb_lpm_clock_ctrl.sv
module tb_lpm_clock_ctrl;

    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             sr_wr = 1'b0;
    logic [3:0]       sr_bits = '0;
    logic             irq = 1'b0;
    logic             reti = 1'b0;
    logic             dco_src_active = 1'b0;
    logic [CNT_W-1:0] settle_len = '0;
    logic             mclk_en, smclk_en, aclk_en, dcgen_en, xtal_en;
    logic [2:0]       mode_o;

    int checks = 0;
    int fails  = 0;

    logic [3:0] m_bits, m_saved;
    int         m_cnt;

    always #2.5 clk = ~clk;

    lpm_clock_ctrl #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst), .sr_wr(sr_wr), .sr_bits(sr_bits), .irq(irq),
        .reti(reti), .dco_src_active(dco_src_active), .settle_len(settle_len),
        .mclk_en(mclk_en), .smclk_en(smclk_en), .aclk_en(aclk_en),
        .dcgen_en(dcgen_en), .xtal_en(xtal_en), .mode_o(mode_o)
    );

    function automatic int mode_of(input logic [3:0] b);
        if (!b[0]) return 0;
        if (b[1]) return 5;
        return 1 + int'({b[3], b[2]});
    endfunction

    // Expected {smclk, aclk, dcgen, xtal} for a mode
    function automatic logic [3:0] src_of(input int m, input logic dco);
        case (m)
            0: return 4'b1111;
            1: return 4'b1111;
            2: return {2'b11, dco, 1'b1};
            3: return 4'b0111;
            4: return 4'b0101;
            default: return 4'b0000;
        endcase
    endfunction

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        int m = mode_of(m_bits);
        logic [3:0] s = src_of(m, dco_src_active);
        cmp(tag, "mode_o", int'(mode_o), m);
        cmp(tag, "mclk_en", int'(mclk_en), int'(m == 0 && m_cnt == 0));
        cmp(tag, "smclk_en", int'(smclk_en), int'(s[3]));
        cmp(tag, "aclk_en", int'(aclk_en), int'(s[2]));
        cmp(tag, "dcgen_en", int'(dcgen_en), int'(s[1]));
        cmp(tag, "xtal_en", int'(xtal_en), int'(s[0]));
    endtask

    task automatic model_edge();
        int m = mode_of(m_bits);
        if (rst) begin
            m_bits = '0; m_saved = '0; m_cnt = 0;
        end else if (m != 0) begin
            if (irq) begin
                logic [3:0] s = src_of(m, dco_src_active);
                m_saved = m_bits;
                m_bits  = '0;
                m_cnt   = s[1] ? 0 : int'(settle_len);
            end
        end else if (m_cnt > 0) begin
            m_cnt--;
        end else if (reti) begin
            m_bits = m_saved; m_saved = '0;
        end else if (sr_wr) begin
            m_bits = sr_bits;
        end
    endtask

    task automatic step(input logic wr, input logic [3:0] b, input logic i,
                        input logic r, input string tag);
        sr_wr = wr; sr_bits = b; irq = i; reti = r;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        sr_wr = 1'b0; irq = 1'b0; reti = 1'b0;
        check_all(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        m_bits = '0; m_saved = '0; m_cnt = 0;
        step(1'b0, 4'h0, 1'b0, 1'b0, "R1");
        rst = 1'b0;
        check_all("R1");

        // R10: return with nothing saved stays running
        step(1'b0, 4'h0, 1'b0, 1'b1, "R10");
        // R9: irq while running ignored
        step(1'b0, 4'h0, 1'b1, 1'b0, "R9");
        // R2: running despite other bits
        step(1'b1, 4'b1110, 1'b0, 1'b0, "R2");
        // R3: level 0
        step(1'b1, 4'b0001, 1'b0, 1'b0, "R3");
        step(1'b0, 4'h0, 1'b1, 1'b0, "R9");
        // R4: level 1 with both source settings
        dco_src_active = 1'b1;
        step(1'b1, 4'b0101, 1'b0, 1'b0, "R4");
        dco_src_active = 1'b0;
        @(negedge clk); check_all("R4");
        step(1'b0, 4'h0, 1'b1, 1'b0, "R9");
        // R5: level 2, writes and returns ignored while asleep (R8)
        step(1'b1, 4'b1001, 1'b0, 1'b0, "R5");
        step(1'b1, 4'b0000, 1'b0, 1'b0, "R8");
        step(1'b0, 4'h0, 1'b0, 1'b1, "R8");
        step(1'b0, 4'h0, 1'b1, 1'b0, "R9");
        // R6: level 3, wake then return restores it (R10)
        step(1'b1, 4'b1101, 1'b0, 1'b0, "R6");
        step(1'b0, 4'h0, 1'b1, 1'b0, "R9");
        step(1'b1, 4'b0001, 1'b0, 1'b1, "R10");
        // R11: wake from level 3 with a settle window of 3
        settle_len = 8'd3;
        step(1'b0, 4'h0, 1'b1, 1'b0, "R11");
        step(1'b1, 4'b0001, 1'b0, 1'b0, "R11");
        step(1'b0, 4'h0, 1'b0, 1'b1, "R11");
        step(1'b0, 4'h0, 1'b0, 1'b0, "R11");
        step(1'b0, 4'h0, 1'b0, 1'b0, "R11");
        // R11: wake from level 0 releases at once
        step(1'b1, 4'b0001, 1'b0, 1'b0, "R3");
        step(1'b0, 4'h0, 1'b1, 1'b0, "R11");
        // R7 and R2: deep sleep codes
        step(1'b1, 4'b0011, 1'b0, 1'b0, "R7");
        step(1'b0, 4'h0, 1'b1, 1'b0, "R11");
        step(1'b1, 4'b1111, 1'b0, 1'b0, "R2");
        step(1'b0, 4'h0, 1'b1, 1'b0, "R11");
        step(1'b0, 4'h0, 1'b0, 1'b0, "R11");
        step(1'b0, 4'h0, 1'b0, 1'b0, "R11");
        step(1'b0, 4'h0, 1'b0, 1'b1, "R10");

        // Random mix: R8 R9 R10 R11
        for (int n = 0; n < 4000; n++) begin
            logic wr, i, r;
            wr = ($urandom % 4) == 0;
            i  = ($urandom % 6) == 0;
            r  = ($urandom % 8) == 0;
            if (($urandom % 50) == 0) dco_src_active = $urandom % 2;
            if (($urandom % 40) == 0) settle_len = CNT_W'($urandom % 6);
            step(wr, 4'($urandom), i, r, "R8-random");
        end

        // R1: reset from a sleep level
        step(1'b1, 4'b1101, 1'b0, 1'b0, "R6");
        rst = 1'b1;
        step(1'b0, 4'h0, 1'b0, 1'b0, "R1");
        rst = 1'b0;
        step(1'b0, 4'h0, 1'b0, 1'b1, "R1");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule